// File: doc/BRIEF.md
# USB OUT Endpoint Controller

This block holds the control and status state for one non-control USB OUT endpoint on the device side. On one side it watches a packet-level receive interface: a strobe for an OUT token aimed at this endpoint, start and end markers for the data packet, a strobe for each payload byte and a CRC-error flag that is valid with the end marker. On the other side it gives firmware a low and a high control/status byte, a 16-bit received byte count split into two bytes, and an interrupt request. The payload storage itself is out of scope. The block keeps a ring of two packet slots that hold only the byte count and error flag of each stored packet.

Two transfer styles are handled. In bulk/interrupt mode every complete packet gets a handshake: ACK when it is stored, NAK when no slot is free, and STALL while firmware has halted the pipe. A packet with a bad CRC is dropped silently. In isochronous mode no handshake is sent. A corrupt packet is still stored and marked, and a packet that finds no free slot is dropped and flagged as an overrun. The packet-ready flag always reflects the head slot. When firmware acknowledges the head while a second packet waits, the flag stays up and a new interrupt fires at once.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: The high status byte reads back only its bit 6, the isochronous mode bit (1 = isochronous, 0 = bulk/interrupt), written by a high-byte write; all other bits read 0.
- R2: A packet that is stored makes bit 0 (packet ready) of the low byte read 1 in the cycle after its end marker, and an interrupt pulse is raised.
- R3: {cnt_hi, cnt_lo} shows the byte count of the head packet, up to 2**CNT_W-1, and reads 0 when no packet is held.
- R4: A low-byte write with bit 0 = 0 while a packet is held releases the head packet. A write with bit 0 = 1 releases nothing.
- R5: With the double-buffer input high, two packets can be held. The input is taken only while no packet is held. Releasing the first of two packets leaves packet ready at 1, shows the second count and pulses the interrupt.
- R6: In bulk/interrupt mode, while bit 5 of the low byte is 1, every packet is answered with STALL (code 2), is not stored, sets bit 6 and raises an interrupt.
- R7: Bit 6 (stall sent) is cleared only by a low-byte write with bit 6 = 0. A new STALL in the same cycle wins over the clear.
- R8: In bulk/interrupt mode, a packet with a CRC error gets no handshake, is not stored and changes no flag.
- R9: In bulk/interrupt mode, with no stall requested, a good packet is answered ACK (code 0) when a slot is free and NAK (code 1), not stored, when none is free. The handshake is a one-cycle hs_valid pulse in the cycle after the end marker.
- R10: In isochronous mode no handshake is sent. A packet finding no free slot is dropped, sets bit 2 (overrun) and raises an interrupt. Bit 2 is cleared by a low-byte write with bit 2 = 0.
- R11: In isochronous mode a CRC-error packet is stored and bit 3 (data error) reads 1 while it is the head. The stall request bit is ignored. Bit 3 follows each new head and is cleared by a low-byte write with bit 3 = 0.
- R12: irq is a one-cycle pulse per event and stays low whenever irq_en was low in the previous cycle.
- R13: Start and end markers that are not preceded by an OUT token have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_token | input | 1 | OUT token for this endpoint received |
| rx_sop | input | 1 | Data packet start |
| rx_byte_vld | input | 1 | One payload byte received this cycle |
| rx_eop | input | 1 | Data packet end (may carry the last byte) |
| rx_crc_err | input | 1 | CRC error, valid with rx_eop |
| irq_en | input | 1 | Interrupt enable |
| cfg_dbl_buf | input | 1 | Use both packet slots |
| reg_wr_lo | input | 1 | Write strobe, low control/status byte |
| reg_wr_hi | input | 1 | Write strobe, high control/status byte |
| reg_wdata | input | 8 | Write data |
| csr_lo | output | 8 | Low control/status byte |
| csr_hi | output | 8 | High control/status byte |
| cnt_lo | output | 8 | Head packet byte count, low byte |
| cnt_hi | output | 8 | Head packet byte count, high byte |
| irq | output | 1 | Interrupt request pulse |
| hs_valid | output | 1 | Handshake request pulse |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |

## Verification
The bench builds the block with its defaults: a two-slot ring and an 11-bit byte counter. A 300-byte packet therefore drives the high count byte, and both single-slot and double-slot operation can be tested by switching the double-buffer input between bursts. The counter limit is set well above any packet the bench sends, so saturation is left alone, while the ring is small enough that NAK and overrun come after one or two packets.

// File: rtl/ep_out_pkg.sv
package ep_out_pkg;
   typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2} hs_e;
   typedef enum logic [1:0] {RX_IDLE = 2'd0, RX_TOK = 2'd1, RX_DATA = 2'd2} rx_st_e;
   localparam int LO_READY      = 0;
   localparam int LO_OVERRUN    = 2;
   localparam int LO_DATAERR    = 3;
   localparam int LO_STALL_REQ  = 5;
   localparam int LO_STALL_SENT = 6;
   localparam int HI_ISO        = 6;
endpackage

// File: rtl/ep_out_rxtrk.sv
module ep_out_rxtrk
   import ep_out_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_token,
   input  logic             rx_sop,
   input  logic             rx_byte_vld,
   input  logic             rx_eop,
   input  logic             rx_crc_err,
   output logic             pkt_done,
   output logic [CNT_W-1:0] pkt_len,
   output logic             pkt_bad
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   rx_st_e           st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      cnt_inc  = (rx_byte_vld && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
      pkt_done = (st_q == RX_DATA) && rx_eop;
      pkt_len  = cnt_inc;
      pkt_bad  = rx_crc_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RX_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            RX_IDLE: if (rx_token) st_q <= RX_TOK;
            RX_TOK: if (rx_sop) begin
               st_q  <= RX_DATA;
               cnt_q <= '0;
            end
            RX_DATA: begin
               if (rx_eop) st_q <= RX_IDLE;
               else        cnt_q <= cnt_inc;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ep_out_slots.sv
module ep_out_slots #(
   parameter int CNT_W  = 11,
   parameter int SLOTS  = 2,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int HELD_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [CNT_W-1:0]  push_len,
   input  logic              push_err,
   output logic [HELD_W-1:0] held,
   output logic [CNT_W-1:0]  head_len,
   output logic              head_err
);
   logic [IDX_W-1:0]  head_q;
   logic [HELD_W-1:0] held_q;
   logic [IDX_W-1:0]  tail;
   logic [CNT_W-1:0]  slot_len [SLOTS];
   logic              slot_err [SLOTS];

   assign tail = head_q + IDX_W'(held_q);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_len[i] <= '0;
            slot_err[i] <= 1'b0;
         end else if (push && tail == IDX_W'(i)) begin
            slot_len[i] <= push_len;
            slot_err[i] <= push_err;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         held_q <= '0;
      end else begin
         if (pop) head_q <= head_q + 1'b1;
         held_q <= held_q + HELD_W'(push) - HELD_W'(pop);
      end
   end

   assign held     = held_q;
   assign head_len = (held_q != '0) ? slot_len[head_q] : '0;
   assign head_err = (held_q != '0) && slot_err[head_q];
endmodule

// File: rtl/ep_out_csr.sv
module ep_out_csr
   import ep_out_pkg::*;
#(
   parameter int SLOTS = 2,
   localparam int HELD_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_lo,
   input  logic              reg_wr_hi,
   input  logic [7:0]        reg_wdata,
   input  logic              irq_en,
   input  logic              cfg_dbl_buf,
   input  logic              pkt_done,
   input  logic              pkt_bad,
   input  logic [HELD_W-1:0] held,
   input  logic              head_err,
   output logic              push,
   output logic              pop,
   output logic [7:0]        csr_lo,
   output logic [7:0]        csr_hi,
   output logic              irq,
   output logic              hs_valid,
   output logic [1:0]        hs_code
);
   logic iso_q, stall_q, sts_q, ovr_q, mask_q, cap_q, irq_q, hsv_q;
   hs_e  hsc_q;
   logic free, ovr_set, sts_set, evt, second, hs_v, any_held;
   hs_e  hs_c;

   always_comb begin
      any_held = (held != '0);
      free     = held < (cap_q ? HELD_W'(2) : HELD_W'(1));
      pop      = reg_wr_lo && !reg_wdata[LO_READY] && any_held;
      second   = pop && (held == HELD_W'(2));
      push     = 1'b0;
      ovr_set  = 1'b0;
      sts_set  = 1'b0;
      evt      = 1'b0;
      hs_v     = 1'b0;
      hs_c     = HS_ACK;
      if (pkt_done) begin
         if (iso_q) begin
            evt = 1'b1;
            if (free) push = 1'b1;
            else      ovr_set = 1'b1;
         end else if (stall_q) begin
            hs_v    = 1'b1;
            hs_c    = HS_STALL;
            sts_set = 1'b1;
            evt     = 1'b1;
         end else if (!pkt_bad) begin
            hs_v = 1'b1;
            if (free) begin
               push = 1'b1;
               evt  = 1'b1;
            end else begin
               hs_c = HS_NAK;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_q   <= 1'b0;
         stall_q <= 1'b0;
         sts_q   <= 1'b0;
         ovr_q   <= 1'b0;
         mask_q  <= 1'b0;
         cap_q   <= 1'b0;
         irq_q   <= 1'b0;
         hsv_q   <= 1'b0;
         hsc_q   <= HS_ACK;
      end else begin
         if (!any_held) cap_q <= cfg_dbl_buf;
         if (reg_wr_hi) iso_q <= reg_wdata[HI_ISO];
         if (reg_wr_lo) stall_q <= reg_wdata[LO_STALL_REQ];
         if (sts_set)
            sts_q <= 1'b1;
         else if (reg_wr_lo && !reg_wdata[LO_STALL_SENT])
            sts_q <= 1'b0;
         if (ovr_set)
            ovr_q <= 1'b1;
         else if (reg_wr_lo && !reg_wdata[LO_OVERRUN])
            ovr_q <= 1'b0;
         if (pop || (push && !any_held))
            mask_q <= 1'b1;
         else if (reg_wr_lo && !reg_wdata[LO_DATAERR])
            mask_q <= 1'b0;
         irq_q <= irq_en && (evt || second);
         hsv_q <= hs_v;
         hsc_q <= hs_c;
      end
   end

   always_comb begin
      csr_lo                = '0;
      csr_lo[LO_READY]      = any_held;
      csr_lo[LO_OVERRUN]    = ovr_q;
      csr_lo[LO_DATAERR]    = head_err && mask_q;
      csr_lo[LO_STALL_REQ]  = stall_q;
      csr_lo[LO_STALL_SENT] = sts_q;
      csr_hi                = '0;
      csr_hi[HI_ISO]        = iso_q;
   end

   assign irq      = irq_q;
   assign hs_valid = hsv_q;
   assign hs_code  = hsc_q;
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
   import ep_out_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int SLOTS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_token,
   input  logic       rx_sop,
   input  logic       rx_byte_vld,
   input  logic       rx_eop,
   input  logic       rx_crc_err,
   input  logic       irq_en,
   input  logic       cfg_dbl_buf,
   input  logic       reg_wr_lo,
   input  logic       reg_wr_hi,
   input  logic [7:0] reg_wdata,
   output logic [7:0] csr_lo,
   output logic [7:0] csr_hi,
   output logic [7:0] cnt_lo,
   output logic [7:0] cnt_hi,
   output logic       irq,
   output logic       hs_valid,
   output logic [1:0] hs_code
);
   localparam int HELD_W = $clog2(SLOTS + 1);

   if (CNT_W < 8 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie between 8 and 16");
   end
   if (SLOTS != 2) begin : g_bad_slots
      $error("SLOTS must be 2");
   end

   logic              pkt_done, pkt_bad, push, pop, head_err;
   logic [CNT_W-1:0]  pkt_len, head_len;
   logic [HELD_W-1:0] held;
   logic [15:0]       cnt16;

   ep_out_rxtrk #(.CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_token(rx_token), .rx_sop(rx_sop),
      .rx_byte_vld(rx_byte_vld), .rx_eop(rx_eop), .rx_crc_err(rx_crc_err),
      .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_bad(pkt_bad)
   );

   ep_out_slots #(.CNT_W(CNT_W), .SLOTS(SLOTS)) u_slots (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .push_len(pkt_len), .push_err(pkt_bad),
      .held(held), .head_len(head_len), .head_err(head_err)
   );

   ep_out_csr #(.SLOTS(SLOTS)) u_csr (
      .clk(clk), .rst_n(rst_n), .reg_wr_lo(reg_wr_lo), .reg_wr_hi(reg_wr_hi),
      .reg_wdata(reg_wdata), .irq_en(irq_en), .cfg_dbl_buf(cfg_dbl_buf),
      .pkt_done(pkt_done), .pkt_bad(pkt_bad), .held(held), .head_err(head_err),
      .push(push), .pop(pop), .csr_lo(csr_lo), .csr_hi(csr_hi),
      .irq(irq), .hs_valid(hs_valid), .hs_code(hs_code)
   );

   assign cnt16  = 16'(head_len);
   assign cnt_lo = cnt16[7:0];
   assign cnt_hi = cnt16[15:8];
endmodule

// File: rtl/ep_out_chk.sv
module ep_out_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_en,
   input logic       reg_wr_lo,
   input logic [7:0] reg_wdata,
   input logic [7:0] csr_lo,
   input logic [7:0] csr_hi,
   input logic [7:0] cnt_lo,
   input logic [7:0] cnt_hi,
   input logic       irq,
   input logic       hs_valid,
   input logic [1:0] hs_code
);
   assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);

   assert_stall_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'd2) |-> csr_lo[6]);

   assert_ack_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'd0) |-> csr_lo[0]);

   assert_nak_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'd1) |-> $past(csr_lo[0]));

   assert_no_hs_in_iso_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> !$past(csr_hi[6]));

   assert_sent_stall_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_lo[6] && !(reg_wr_lo && !reg_wdata[6])) |=> csr_lo[6]);

   assert_empty_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_lo[0] |-> (cnt_lo == 8'd0 && cnt_hi == 8'd0));
endmodule

bind usb_out_ep_ctrl ep_out_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .reg_wr_lo(reg_wr_lo),
   .reg_wdata(reg_wdata), .csr_lo(csr_lo), .csr_hi(csr_hi), .cnt_lo(cnt_lo),
   .cnt_hi(cnt_hi), .irq(irq), .hs_valid(hs_valid), .hs_code(hs_code)
);

// File: tb/sim_usb_out_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_out_ep_ctrl;
   localparam int MAXC = 2047;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tok = 0, sop = 0, bv = 0, eop = 0, crc = 0;
   logic ien = 1, dbl = 0, wlo = 0, whi = 0;
   logic [7:0] wd = 8'h00;
   logic [7:0] csr_lo, csr_hi, cnt_lo, cnt_hi;
   logic irq, hs_valid;
   logic [1:0] hs_code;

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model state
   int m_st, m_cnt;
   int mq_len[$];
   bit mq_err[$];
   bit m_cap, m_stallc, m_sts, m_ovr, m_mask, m_iso, m_irq, m_hsv;
   int m_hsc;

   always #10 clk = ~clk;

   usb_out_ep_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .rx_token(tok), .rx_sop(sop), .rx_byte_vld(bv),
      .rx_eop(eop), .rx_crc_err(crc), .irq_en(ien), .cfg_dbl_buf(dbl),
      .reg_wr_lo(wlo), .reg_wr_hi(whi), .reg_wdata(wd), .csr_lo(csr_lo),
      .csr_hi(csr_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq(irq),
      .hs_valid(hs_valid), .hs_code(hs_code)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit done, free, pop, push, ovr_set, sts_set, evt;
      int len, held;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; mq_len.delete(); mq_err.delete();
         m_cap = 0; m_stallc = 0; m_sts = 0; m_ovr = 0; m_mask = 0;
         m_iso = 0; m_irq = 0; m_hsv = 0; m_hsc = 0;
         return;
      end
      done = (m_st == 2) && eop;
      len = m_cnt + (bv ? 1 : 0);
      if (len > MAXC) len = MAXC;
      held = mq_len.size();
      free = held < (m_cap ? 2 : 1);
      pop = wlo && !wd[0] && held > 0;
      push = 0; ovr_set = 0; sts_set = 0; evt = 0;
      m_hsv = 0;
      if (done) begin
         if (m_iso) begin
            evt = 1;
            if (free) push = 1; else ovr_set = 1;
         end else if (m_stallc) begin
            m_hsv = 1; m_hsc = 2; sts_set = 1; evt = 1;
         end else if (!crc) begin
            m_hsv = 1;
            if (free) begin push = 1; evt = 1; m_hsc = 0; end
            else m_hsc = 1;
         end
      end
      m_irq = ien && (evt || (pop && held == 2));
      if (held == 0) m_cap = dbl;
      if (whi) m_iso = wd[6];
      if (wlo) begin
         m_stallc = wd[5];
         if (!wd[6]) m_sts = 0;
         if (!wd[2]) m_ovr = 0;
         if (!wd[3]) m_mask = 0;
      end
      if (sts_set) m_sts = 1;
      if (ovr_set) m_ovr = 1;
      if (pop || (push && held == 0)) m_mask = 1;
      if (pop) begin void'(mq_len.pop_front()); void'(mq_err.pop_front()); end
      if (push) begin mq_len.push_back(len); mq_err.push_back(crc); end
      case (m_st)
         0: if (tok) m_st = 1;
         1: if (sop) begin m_st = 2; m_cnt = 0; end
         default: if (eop) m_st = 0; else if (bv && m_cnt < MAXC) m_cnt++;
      endcase
   endtask

   task automatic compare();
      bit opr, derr;
      int ecnt;
      opr = mq_len.size() > 0;
      derr = opr && mq_err[0] && m_mask;
      ecnt = opr ? mq_len[0] : 0;
      chk("R2 ready bit", csr_lo[0], opr);
      chk("R10 overrun bit", csr_lo[2], m_ovr);
      chk("R11 data error bit", csr_lo[3], derr);
      chk("R6 stall request bit", csr_lo[5], m_stallc);
      chk("R7 stall sent bit", csr_lo[6], m_sts);
      chk("R1 unused low bits", {csr_lo[7], csr_lo[4], csr_lo[1]}, 0);
      chk("R1 high byte", csr_hi, m_iso ? 8'h40 : 8'h00);
      chk("R3 count", {cnt_hi, cnt_lo}, ecnt);
      chk("R12 irq", irq, m_irq);
      chk("R9 hs valid", hs_valid, m_hsv);
      if (m_hsv && hs_valid) chk("R9 hs code", hs_code, m_hsc);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic send(int n, bit badcrc);
      tok = 1; cyc(); tok = 0;
      sop = 1; cyc(); sop = 0;
      for (int i = 0; i < n - 1; i++) begin bv = 1; cyc(); end
      bv = (n > 0); eop = 1; crc = badcrc; cyc();
      bv = 0; eop = 0; crc = 0;
   endtask

   task automatic wr_lo(logic [7:0] v);
      wlo = 1; wd = v; cyc(); wlo = 0; wd = 8'h00;
   endtask

   task automatic wr_hi(logic [7:0] v);
      whi = 1; wd = v; cyc(); whi = 0; wd = 8'h00;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      cyc(); cyc();
      chk("R2 reset low byte", csr_lo, 0);
      chk("R3 reset count", {cnt_hi, cnt_lo}, 0);
      rst_n = 1;
      cyc();

      // bulk, single slot
      send(5, 0);
      chk("R9 ack code", hs_code, 0);
      chk("R2 ready after packet", csr_lo[0], 1);
      chk("R3 count five", cnt_lo, 5);
      chk("R12 irq on packet", irq, 1);
      send(4, 0);
      chk("R9 nak when full", hs_code, 1);
      chk("R9 nak keeps count", cnt_lo, 5);
      wr_lo(8'h01);
      chk("R4 write one keeps packet", csr_lo[0], 1);
      wr_lo(8'h00);
      chk("R4 release empties", csr_lo[0], 0);

      // start/end markers without a token
      sop = 1; cyc(); sop = 0; bv = 1; cyc(); eop = 1; cyc(); bv = 0; eop = 0; cyc();
      chk("R13 no token no packet", csr_lo[0], 0);
      chk("R13 no token no handshake", hs_valid, 0);

      // double buffering
      dbl = 1; cyc(); cyc();
      send(3, 0); send(7, 0);
      chk("R5 second stored ack", hs_code, 0);
      send(2, 0);
      chk("R5 third nak", hs_code, 1);
      dbl = 0;
      wr_lo(8'h00);
      chk("R5 ready stays", csr_lo[0], 1);
      chk("R5 second count", cnt_lo, 7);
      chk("R5 second irq", irq, 1);
      send(9, 0);
      chk("R5 cfg held while busy", hs_code, 0);
      wr_lo(8'h00); wr_lo(8'h00);
      cyc();
      send(1, 0); send(1, 0);
      chk("R5 single after empty", hs_code, 1);
      wr_lo(8'h00);

      // stall
      wr_lo(8'h20);
      send(6, 0);
      chk("R6 stall code", hs_code, 2);
      chk("R6 not stored", csr_lo[0], 0);
      chk("R7 stall sent set", csr_lo[6], 1);
      wr_lo(8'h60);
      chk("R7 write one keeps", csr_lo[6], 1);
      wr_lo(8'h20);
      chk("R7 write zero clears", csr_lo[6], 0);
      wr_lo(8'h00);

      // bulk CRC error
      send(4, 1);
      chk("R8 bad crc not stored", csr_lo[0], 0);
      cyc();

      // large packet reaches high count byte
      send(300, 0);
      chk("R3 high byte", cnt_hi, 1);
      chk("R3 low byte", cnt_lo, 44);
      wr_lo(8'h00);

      // isochronous
      wr_hi(8'hFF);
      chk("R1 iso bit only", csr_hi, 8'h40);
      dbl = 1; cyc(); cyc();
      wr_lo(8'h20);
      send(8, 1);
      chk("R11 stored with error", csr_lo[3], 1);
      chk("R10 no handshake", hs_valid, 0);
      send(6, 0);
      send(5, 0);
      chk("R10 overrun set", csr_lo[2], 1);
      chk("R10 overrun irq", irq, 1);
      wr_lo(8'h29);
      chk("R10 overrun cleared", csr_lo[2], 0);
      chk("R11 head error kept", csr_lo[3], 1);
      wr_lo(8'h20);
      chk("R11 new head no error", csr_lo[3], 0);
      chk("R11 count follows head", cnt_lo, 6);
      wr_lo(8'h00);

      // interrupts disabled
      ien = 0; cyc();
      send(3, 0);
      chk("R12 masked irq", irq, 0);
      ien = 1;
      wr_lo(8'h00);
      wr_hi(8'h00);
      repeat (3) cyc();

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule